// File: doc/BRIEF.md
# Two-Phase Program Address Path

This block produces the memory address for a small accumulator processor. It keeps two storage elements, an address latch that drives the address bus and a program counter latch that holds the address of the next instruction. Every storage element is a level-sensitive latch. Two non-overlapping clock phases open them in turn, so the loop from the address latch through the incrementer into the PC latch and back through the selector is never transparent end to end.

The block is a row of identical bit slices. Each slice has an AND-OR selector that passes either the external address bit or the PC bit, an address latch bit, a half adder that forms one bit of address plus one, and a PC latch bit. The carry ripples from slice to slice, and bit 0 receives a constant carry of one. A controller raises `pick_pc` to step through the program, raises `pick_ext` to jump to an operand address, or leaves both low to load zero, which is how the PC is reset. The width is a parameter, so the path grows one slice at a time.

Top module: `lt_addr_path`

## Requirements
- R1: With `pick_pc`=1 and `pick_ext`=0, each full cycle (a `phase1` pulse followed by a `phase2` pulse) advances `addr_q` by exactly one, modulo 2^WIDTH.
- R2: With `pick_pc`=0 and `pick_ext`=0, a `phase1` pulse loads all zeros into `addr_q`, and the `phase2` pulse that follows sets `pc_q` to 1.
- R3: With `pick_ext`=1 and `pick_pc`=0, a `phase1` pulse loads `ext_addr` into `addr_q`, and the next `phase2` pulse sets `pc_q` to `ext_addr`+1. Raising both selects together is a controller error (the selector would output the bitwise OR of the two sources) and is flagged by an assertion.
- R4: When `addr_q` holds all ones, the next step gives `pc_q` = 0 and then `addr_q` = 0; no carry leaves the top slice.
- R5: While `phase1` is low, `addr_q` holds its value whatever `ext_addr`, `pick_ext`, `pick_pc` or `phase2` do.
- R6: While `phase2` is low, `pc_q` holds its value; while `phase2` is high, `pc_q` takes `addr_q`+1 modulo 2^WIDTH.
- R7: `phase1` and `phase2` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phase1 | input | 1 | Opens the address latch while high |
| phase2 | input | 1 | Opens the program counter latch while high |
| pick_ext | input | 1 | Selects the external address into the address latch |
| pick_pc | input | 1 | Selects the program counter into the address latch |
| ext_addr | input | WIDTH | External address, for example an operand field |
| addr_q | output | WIDTH | Address latch output, drives the address bus |
| pc_q | output | WIDTH | Program counter latch output |

## Verification
The bench builds the path at its default width of six slices, which keeps the whole address space of 64 values within a short run: a full lap of counting from zero back to zero, the carry rippling through every slice at the all-ones step, and jumps to arbitrary operand addresses. Single-phase pulses, with the other phase held low, separate the hold behaviour of each latch from the other, so a latch that is open on the wrong phase shows up directly at `addr_q` or `pc_q`.

// File: rtl/lt_addr_pkg.sv
package lt_addr_pkg;

    // Outputs of one bit slice toward its neighbours and the ports.
    typedef struct packed {
        logic addr_bit;
        logic pc_bit;
        logic carry;
    } slice_out_t;

    localparam int unsigned DEFAULT_WIDTH = 6;

endpackage

// File: rtl/lt_bit_latch.sv
module lt_bit_latch (
    input  logic en,
    input  logic d,
    output logic q
);

    // Transparent while en is high, holds while en is low.
    always_latch begin
        if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lt_half_adder.sv
module lt_half_adder (
    input  logic a,
    input  logic cin,
    output logic sum,
    output logic cout
);

    always_comb begin
        sum  = a ^ cin;
        cout = a & cin;
    end

endmodule

// File: rtl/lt_addr_slice.sv
module lt_addr_slice
    import lt_addr_pkg::*;
(
    input  logic       phase1,
    input  logic       phase2,
    input  logic       pick_ext,
    input  logic       pick_pc,
    input  logic       ext_bit,
    input  logic       carry_in,
    output slice_out_t so
);

    logic sel_bit;
    logic a_bit;
    logic p_bit;
    logic inc_bit;
    logic c_out;

    // AND-OR selector: zero when neither select is high.
    always_comb begin
        sel_bit = (pick_ext & ext_bit) | (pick_pc & p_bit);
    end

    lt_bit_latch u_addr_latch (
        .en (phase1),
        .d  (sel_bit),
        .q  (a_bit)
    );

    lt_half_adder u_inc (
        .a    (a_bit),
        .cin  (carry_in),
        .sum  (inc_bit),
        .cout (c_out)
    );

    lt_bit_latch u_pc_latch (
        .en (phase2),
        .d  (inc_bit),
        .q  (p_bit)
    );

    always_comb begin
        so.addr_bit = a_bit;
        so.pc_bit   = p_bit;
        so.carry    = c_out;
    end

    // A phase1 pulse with no select must leave this slice at zero.
    always @(negedge phase1) begin
        if (!pick_ext && !pick_pc) begin
            AST_ZERO_LOAD: assert (a_bit == 1'b0) else $error("zero load failed"); // R2
        end
    end

endmodule

// File: rtl/lt_addr_path.sv
module lt_addr_path
    import lt_addr_pkg::*;
#(
    parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
    input  logic             phase1,
    input  logic             phase2,
    input  logic             pick_ext,
    input  logic             pick_pc,
    input  logic [WIDTH-1:0] ext_addr,
    output logic [WIDTH-1:0] addr_q,
    output logic [WIDTH-1:0] pc_q
);

    localparam int unsigned CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] carry;
    slice_out_t       slice_o [WIDTH];

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        lt_addr_slice u_slice (
            .phase1   (phase1),
            .phase2   (phase2),
            .pick_ext (pick_ext),
            .pick_pc  (pick_pc),
            .ext_bit  (ext_addr[i]),
            .carry_in (carry[i]),
            .so       (slice_o[i])
        );
        assign addr_q[i]  = slice_o[i].addr_bit;
        assign pc_q[i]    = slice_o[i].pc_bit;
        assign carry[i+1] = slice_o[i].carry;
    end

    // Top carry is dropped: the counter wraps.
    logic top_carry_unused;
    assign top_carry_unused = carry[WIDTH];

    // ---- checks on the phase discipline and the latch behaviour ----
    logic             seen_p1 = 1'b0;
    logic [WIDTH-1:0] addr_snap = '0;

    always @(posedge phase1) begin
        AST_PHASE_OVERLAP_A: assert (!phase2) else $error("phase overlap"); // R7
    end

    always @(posedge phase2) begin
        AST_PHASE_OVERLAP_B: assert (!phase1) else $error("phase overlap"); // R7
        if (seen_p1) begin
            AST_ADDR_HOLD: assert (addr_q == addr_snap) else $error("addr moved"); // R5
        end
    end

    always @(negedge phase1) begin
        seen_p1   <= 1'b1;
        addr_snap <= addr_q;
        AST_SEL_EXCLUSIVE: assert (!(pick_ext && pick_pc)) else $error("both selects"); // R3
        if (pick_ext && !pick_pc) begin
            AST_EXT_LOAD: assert (addr_q == ext_addr) else $error("ext load"); // R3
        end
    end

    always @(negedge phase2) begin
        if (seen_p1) begin
            AST_PC_STEP: assert (pc_q == WIDTH'(addr_q + 1'b1)) else $error("pc step"); // R6
        end
    end

endmodule

// File: tb/lt_addr_path_test.sv
`timescale 1ns/100ps
module lt_addr_path_test;

    localparam int unsigned W = 6;
    localparam int unsigned MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         phase1 = 1'b0;
    logic         phase2 = 1'b0;
    logic         pick_ext = 1'b0;
    logic         pick_pc = 1'b0;
    logic [W-1:0] ext_addr = '0;
    logic [W-1:0] addr_q;
    logic [W-1:0] pc_q;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lt_addr_path #(.WIDTH(W)) uut (
        .phase1   (phase1),
        .phase2   (phase2),
        .pick_ext (pick_ext),
        .pick_pc  (pick_pc),
        .ext_addr (ext_addr),
        .addr_q   (addr_q),
        .pc_q     (pc_q)
    );

    always @(phase1 or phase2) begin
        if (phase1 && phase2) overlaps++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse1();
        @(posedge clk);
        #0.5 phase1 = 1'b1;
        #1.5 phase1 = 1'b0;
        #0.5;
    endtask

    task automatic pulse2();
        @(posedge clk);
        #0.5 phase2 = 1'b1;
        #1.5 phase2 = 1'b0;
        #0.5;
    endtask

    task automatic step();
        pulse1();
        pulse2();
    endtask

    task automatic set_mode(input bit e, input bit p, input int a);
        pick_ext = e;
        pick_pc  = p;
        ext_addr = W'(a);
    endtask

    task automatic t_reset();
        set_mode(0, 0, 21);
        step();
        check("R2 addr after zero load", addr_q, 0);
        check("R2 pc after zero load", pc_q, 1);
    endtask

    task automatic t_count();
        set_mode(0, 1, 0);
        for (int i = 1; i <= 10; i++) begin
            step();
            check("R1 count", addr_q, i);
        end
    endtask

    task automatic t_jump();
        set_mode(1, 0, 42);
        step();
        check("R3 jump addr", addr_q, 42);
        check("R3 jump pc", pc_q, 43);
        set_mode(0, 1, 0);
        for (int i = 1; i <= 3; i++) begin
            step();
            check("R1 count after jump", addr_q, 42 + i);
        end
    endtask

    task automatic t_wrap();
        set_mode(1, 0, 62);
        step();
        set_mode(0, 1, 0);
        step();
        check("R4 reach all ones", addr_q, MASK);
        check("R4 pc wraps", pc_q, 0);
        step();
        check("R4 addr wraps", addr_q, 0);
        check("R4 pc after wrap", pc_q, 1);
    endtask

    task automatic t_full_lap();
        set_mode(0, 0, 0);
        step();
        set_mode(0, 1, 0);
        for (int i = 1; i <= 64; i++) begin
            step();
            check("R1 lap count", addr_q, i & MASK);
        end
    endtask

    task automatic t_hold_addr();
        set_mode(1, 0, 9);
        step();
        set_mode(1, 0, 50);
        #3;
        check("R5 addr holds on ext change", addr_q, 9);
        set_mode(0, 0, 0);
        pulse2();
        check("R5 addr holds over phase2", addr_q, 9);
        check("R6 pc follows during phase2", pc_q, 10);
    endtask

    task automatic t_hold_pc();
        set_mode(1, 0, 17);
        pulse1();
        check("R6 addr loads on phase1 only", addr_q, 17);
        check("R6 pc holds without phase2", pc_q, 10);
        pulse2();
        check("R6 pc after phase2", pc_q, 18);
    endtask

    initial begin
        #10;
        t_reset();
        t_count();
        t_jump();
        t_wrap();
        t_full_lap();
        t_hold_addr();
        t_hold_pc();
        check("R7 no phase overlap", overlaps, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule